// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block produces the external bus timing of an 8-bit microcontroller core. For each machine cycle the core presents one request: a code fetch, an external data read, an external data write, or nothing. The sequencer then drives the address-latch strobe, the program-store strobe, the read and write strobes, the low port (the multiplexed low address byte and data) and the high port (the upper address byte, or the port latch value) across the cycle.

A machine cycle is six states. In normal timing each state takes two oscillator clocks, so a cycle takes 12 clocks. In double-speed timing each state takes one clock, so a cycle takes 6. The block runs on the oscillator clock. It counts a phase from 0 to 11, which steps by 1 in normal timing and by 2 in double-speed timing. It samples the request and the speed mode on the clock edge that ends each cycle. Code fetches go to internal memory or to the external bus, depending on the external-code enable input and on the fetch address.

Top module: `xbus_strobe_seq`

## Requirements
- R1: While `rst` is high, and on the clock after it is raised in the middle of a cycle, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, and `p0_oe` is 0.
- R2: A machine cycle lasts 12 clocks when the latched mode is normal and 6 clocks in double-speed mode. `cycle_start` is high on the first clock of every cycle. The request inputs and `x2_mode` are sampled on the edge that ends the previous cycle. `req_kind` is encoded as 0 idle, 1 fetch, 2 data read, 3 data write.
- R3: Every external fetch cycle carries two address-latch pulses, one at the start of each half. A pulse is 2 clocks long on clocks 0 and 6 in normal mode, and 1 clock long on clocks 0 and 3 in double-speed mode. An idle cycle has no strobes.
- R4: A fetch is internal when `ext_code_en` is 1 and `req_addr` is below 8000h. Any other fetch is external. An internal fetch never drives `psen_n` low or `p0_oe` high.
- R5: An external fetch drives `psen_n` low twice per cycle, in states 2 to 3 of each half: clocks 3 and 9 onward in normal mode, clocks 2 and 5 in double-speed mode. During each address-latch pulse `p0_out` carries the low byte of the fetch address. That address is `req_addr` in the first half and `req_addr+1` in the second. `p0_oe` is 0 while `psen_n` is low. `ale` is never high together with a low `psen_n`.
- R6: When `ale_disable` is 1, an internal fetch cycle has no address-latch pulse. External fetch cycles and data cycles still pulse.
- R7: A data cycle has exactly one address-latch pulse, in the first half, and no program-store pulse. Its strobe (`rd_n` for a read, `wr_n` for a write) is low for one contiguous window over phases 3 to 10: 8 clocks in normal mode, 4 clocks in double-speed mode. `rd_n` and `wr_n` are never low together.
- R8: In a data cycle `p0_out` carries `req_addr[7:0]` during the address-latch pulse. A write then drives `wr_byte` from phase 3 to the end of the cycle. A read leaves `p0_oe` at 0 while `rd_n` is low, captures `p0_in` on the last clock of the window, and holds it on `rd_byte` from the next cycle onward.
- R9: `p2_out` carries the upper byte of the fetch address for an external fetch, and the upper byte of `req_addr` for a data cycle with `req_wide`=1. In every other case, including a data cycle with `req_wide`=0, it carries `p2_latch`.
- R10: `psen_n` is never low together with `rd_n` or `wr_n`, and `ale` is 0 while either data strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| x2_mode | input | 1 | 1 selects double-speed timing for the next cycle |
| ext_code_en | input | 1 | 1 lets fetches below the internal limit use internal memory |
| ale_disable | input | 1 | Suppresses the address-latch strobe during internal fetches |
| req_kind | input | 2 | 0 idle, 1 fetch, 2 data read, 3 data write |
| req_addr | input | 16 | Fetch address or data address |
| req_wide | input | 1 | 1 for a 16-bit data address, 0 for an 8-bit one |
| p2_latch | input | 8 | High port latch value |
| wr_byte | input | 8 | Byte to write in a data write |
| p0_in | input | 8 | Byte read from the low port |
| cycle_start | output | 1 | High on the first clock of each machine cycle |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Low port drive value |
| p0_oe | output | 1 | Low port output enable |
| p2_out | output | 8 | High port drive value |
| rd_byte | output | 8 | Byte captured by the last data read |

## Verification
The assertions check the strobe relationships on every clock. The program-store strobe never overlaps a data strobe, read and write never overlap, and the address-latch strobe stays low inside a data window. The low port is released while code or read data comes in, and each data strobe window is contiguous. Pulse counts per cycle, the placement of each strobe for both speed modes, the routing of fetches around the 8000h limit, the effect of the latch-disable bit, and the port contents at the strobe edges all depend on the request, so only the bench's scenarios can show them.

// File: rtl/xbus_strobe_seq.sv
module xbus_strobe_seq #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INT_LIMIT = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              x2_mode,
  input  logic              ext_code_en,
  input  logic              ale_disable,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wide,
  input  logic [ADDR_W-9:0] p2_latch,
  input  logic [7:0]        wr_byte,
  input  logic [7:0]        p0_in,
  output logic              cycle_start,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [7:0]        p0_out,
  output logic              p0_oe,
  output logic [ADDR_W-9:0] p2_out,
  output logic [7:0]        rd_byte
);
  localparam logic [1:0] K_IDLE = 2'd0, K_FETCH = 2'd1, K_READ = 2'd2, K_WRITE = 2'd3;
  localparam logic [3:0] LAST_PH = 4'd11;

  logic [3:0]        ph;
  logic              c_x2, c_ea, c_aoff, c_wide;
  logic [1:0]        c_kind;
  logic [ADDR_W-1:0] c_addr;
  logic [7:0]        c_wd;

  logic [3:0]        step, hp;
  logic              wrap, half2;
  logic              is_fetch, int_fetch, ext_fetch, is_data, is_rd, is_wr, dwin;
  logic [ADDR_W-1:0] fa;

  assign step  = c_x2 ? 4'd2 : 4'd1;
  assign wrap  = ph >= (LAST_PH + 4'd1 - step);
  assign half2 = ph >= 4'd6;
  assign hp    = half2 ? ph - 4'd6 : ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      c_x2   <= 1'b0;
      c_ea   <= 1'b0;
      c_aoff <= 1'b0;
      c_wide <= 1'b0;
      c_kind <= K_IDLE;
      c_addr <= '0;
      c_wd   <= '0;
    end else if (wrap) begin
      ph     <= '0;
      c_x2   <= x2_mode;
      c_ea   <= ext_code_en;
      c_aoff <= ale_disable;
      c_wide <= req_wide;
      c_kind <= req_kind;
      c_addr <= req_addr;
      c_wd   <= wr_byte;
    end else begin
      ph <= ph + step;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_byte <= '0;
    else if (is_rd && ph == 4'd10)
      rd_byte <= p0_in;
  end

  assign is_fetch  = c_kind == K_FETCH;
  assign int_fetch = is_fetch && c_ea && (c_addr < INT_LIMIT);
  assign ext_fetch = is_fetch && !int_fetch;
  assign is_rd     = c_kind == K_READ;
  assign is_wr     = c_kind == K_WRITE;
  assign is_data   = is_rd || is_wr;
  assign dwin      = is_data && ph >= 4'd3 && ph <= 4'd10;
  assign fa        = half2 ? c_addr + ADDR_W'(1) : c_addr;

  assign cycle_start = ph == 4'd0;

  assign ale = (hp < 4'd2) &&
               (ext_fetch || (int_fetch && !c_aoff) || (is_data && !half2));

  assign psen_n = !(ext_fetch && hp >= 4'd3);
  assign rd_n   = !(dwin && is_rd);
  assign wr_n   = !(dwin && is_wr);

  always_comb begin
    p0_oe  = 1'b0;
    p0_out = 8'h00;
    if (ext_fetch && hp < 4'd3) begin
      p0_oe  = 1'b1;
      p0_out = fa[7:0];
    end else if (is_data && ph < 4'd3) begin
      p0_oe  = 1'b1;
      p0_out = c_addr[7:0];
    end else if (is_wr) begin
      p0_oe  = 1'b1;
      p0_out = c_wd;
    end
  end

  always_comb begin
    if (ext_fetch)
      p2_out = fa[ADDR_W-1:8];
    else if (is_data && c_wide)
      p2_out = c_addr[ADDR_W-1:8];
    else
      p2_out = p2_latch;
  end
endmodule

// File: rtl/xbus_strobe_seq_chk.sv
module xbus_strobe_seq_chk (
  input logic clk,
  input logic rst,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic p0_oe
);
  AST_PSEN_RD_EXCL: assert property (@(posedge clk) disable iff (rst) !(!psen_n && !rd_n)); // R10
  AST_PSEN_WR_EXCL: assert property (@(posedge clk) disable iff (rst) !(!psen_n && !wr_n)); // R10
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst) !(!rd_n && !wr_n)); // R7
  AST_NO_ALE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst) (!rd_n || !wr_n) |-> !ale); // R10
  AST_ALE_NOT_WITH_PSEN: assert property (@(posedge clk) disable iff (rst) ale |-> psen_n); // R5
  AST_BUS_FREE_ON_READ: assert property (@(posedge clk) disable iff (rst) !rd_n |-> !p0_oe); // R8
  AST_BUS_FREE_ON_CODE: assert property (@(posedge clk) disable iff (rst) !psen_n |-> !p0_oe); // R5
  AST_RD_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst) $rose(rd_n) |=> rd_n); // R7
  AST_WR_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst) $rose(wr_n) |=> wr_n); // R7
endmodule

bind xbus_strobe_seq xbus_strobe_seq_chk u_chk (.*);

// File: tb/xbus_strobe_seq_test.sv
module xbus_strobe_seq_test;
  localparam int PERIOD = 10;
  localparam logic [1:0] K_IDLE = 2'd0, K_FETCH = 2'd1, K_READ = 2'd2, K_WRITE = 2'd3;

  typedef struct packed {
    logic        x2;
    logic        ea;
    logic        aoff;
    logic [1:0]  kind;
    logic        wide;
    logic [15:0] addr;
    logic [7:0]  p2l;
    logic [7:0]  wd;
    logic [7:0]  p0i;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, K_FETCH, 1'b0, 16'h12FF, 8'hA1, 8'h00, 8'h00},
    '{1'b0, 1'b1, 1'b0, K_FETCH, 1'b0, 16'h7FFF, 8'hA2, 8'h00, 8'h00},
    '{1'b0, 1'b1, 1'b0, K_FETCH, 1'b0, 16'h8000, 8'hA3, 8'h00, 8'h00},
    '{1'b0, 1'b1, 1'b1, K_FETCH, 1'b0, 16'h0100, 8'hA4, 8'h00, 8'h00},
    '{1'b0, 1'b1, 1'b1, K_FETCH, 1'b0, 16'h9000, 8'hA5, 8'h00, 8'h00},
    '{1'b0, 1'b0, 1'b0, K_READ,  1'b1, 16'hA55A, 8'hA6, 8'h00, 8'h3C},
    '{1'b0, 1'b1, 1'b1, K_WRITE, 1'b0, 16'h0077, 8'hC3, 8'h96, 8'h00},
    '{1'b1, 1'b0, 1'b0, K_FETCH, 1'b0, 16'h4321, 8'hA7, 8'h00, 8'h00},
    '{1'b1, 1'b0, 1'b0, K_READ,  1'b0, 16'h00F0, 8'h5A, 8'h00, 8'hE1},
    '{1'b1, 1'b0, 1'b0, K_WRITE, 1'b1, 16'h1357, 8'hA8, 8'h2B, 8'h00},
    '{1'b1, 1'b1, 1'b0, K_FETCH, 1'b0, 16'h0010, 8'hA9, 8'h00, 8'h00},
    '{1'b0, 1'b0, 1'b0, K_IDLE,  1'b0, 16'hFFFF, 8'h6E, 8'h00, 8'h00}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic x2_mode = 1'b0, ext_code_en = 1'b0, ale_disable = 1'b0, req_wide = 1'b0;
  logic [1:0]  req_kind = K_IDLE;
  logic [15:0] req_addr = '0;
  logic [7:0]  p2_latch = '0, wr_byte = '0, p0_in = '0;
  logic cycle_start, ale, psen_n, rd_n, wr_n, p0_oe;
  logic [7:0] p0_out, p2_out, rd_byte;

  int compared = 0, mismatched = 0;
  logic       s_ale [12], s_psen [12], s_rd [12], s_wr [12], s_oe [12];
  logic [7:0] s_p0 [12], s_p2 [12];

  always #(PERIOD/2) clk = ~clk;

  xbus_strobe_seq uut (
    .clk(clk), .rst(rst), .x2_mode(x2_mode), .ext_code_en(ext_code_en),
    .ale_disable(ale_disable), .req_kind(req_kind), .req_addr(req_addr),
    .req_wide(req_wide), .p2_latch(p2_latch), .wr_byte(wr_byte), .p0_in(p0_in),
    .cycle_start(cycle_start), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out), .rd_byte(rd_byte)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int len, na, np, nr, nw;
    logic internal;
    logic [15:0] a2;
    logic [7:0] hi_exp;
    x2_mode = v.x2; ext_code_en = v.ea; ale_disable = v.aoff; req_kind = v.kind;
    req_addr = v.addr; req_wide = v.wide; p2_latch = v.p2l; wr_byte = v.wd; p0_in = v.p0i;
    do @(negedge clk); while (!cycle_start);
    len = v.x2 ? 6 : 12;
    for (int k = 0; k < len; k++) begin
      if (k > 0) @(negedge clk);
      s_ale[k] = ale; s_psen[k] = psen_n; s_rd[k] = rd_n; s_wr[k] = wr_n;
      s_oe[k] = p0_oe; s_p0[k] = p0_out; s_p2[k] = p2_out;
    end
    req_kind = K_IDLE;
    na = 0; np = 0; nr = 0; nw = 0;
    for (int k = 0; k < len; k++) begin
      if (s_ale[k] && (k == 0 || !s_ale[k-1])) na++;
      if (!s_psen[k] && (k == 0 || s_psen[k-1])) np++;
      if (!s_rd[k]) nr++;
      if (!s_wr[k]) nw++;
    end
    internal = v.kind == K_FETCH && v.ea && v.addr < 16'h8000;
    a2 = v.addr + 16'd1;
    if (v.kind == K_FETCH && !internal) begin
      chk("R3", "ale pulses ext fetch", na, 2);
      chk("R5", "psen pulses ext fetch", np, 2);
      chk("R5", "p0 addr at first ale", {s_oe[0], s_p0[0]}, {1'b1, v.addr[7:0]});
      chk("R5", "p0 addr at second ale", {s_ale[len/2], s_p0[len/2]}, {1'b1, a2[7:0]});
      chk("R9", "p2 second half", s_p2[len/2], a2[15:8]);
      chk("R5", "psen low & p0 released", {s_psen[v.x2 ? 2 : 3], s_oe[v.x2 ? 2 : 3]}, 0);
      chk("R5", "second psen placement", s_psen[v.x2 ? 5 : 9], 0);
      hi_exp = v.addr[15:8];
    end else if (v.kind == K_FETCH) begin
      chk("R6", "ale pulses internal fetch", na, v.aoff ? 0 : 2);
      chk("R4", "no psen internal fetch", np, 0);
      chk("R4", "p0 not driven internal", s_oe[v.x2 ? 2 : 3], 0);
      hi_exp = v.p2l;
    end else if (v.kind == K_IDLE) begin
      chk("R3", "idle strobes", {na[3:0], np[3:0], nr[3:0], nw[3:0]}, 0);
      hi_exp = v.p2l;
    end else begin
      chk("R7", "ale pulses data", na, 1);
      chk("R7", "psen pulses data", np, 0);
      chk("R7", "rd window length", nr, v.kind == K_READ ? (v.x2 ? 4 : 8) : 0);
      chk("R7", "wr window length", nw, v.kind == K_WRITE ? (v.x2 ? 4 : 8) : 0);
      chk("R8", "p0 data addr at ale", {s_ale[0], s_oe[0], s_p0[0]}, {2'b11, v.addr[7:0]});
      if (v.kind == K_WRITE)
        chk("R8", "write data on p0", {s_oe[v.x2 ? 2 : 4], s_p0[v.x2 ? 2 : 4]}, {1'b1, v.wd});
      else
        chk("R8", "p0 released in read", s_oe[v.x2 ? 2 : 4], 0);
      hi_exp = v.wide ? v.addr[15:8] : v.p2l;
    end
    chk("R9", "p2 first half", s_p2[0], hi_exp);
    @(negedge clk);
    chk("R2", "cycle length", cycle_start, 1);
    if (v.kind == K_READ) chk("R8", "read byte captured", rd_byte, v.p0i);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "strobes in reset", {ale, psen_n, rd_n, wr_n, p0_oe}, 5'b01110);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R7/R1: mid-window reset drops the write strobe
    x2_mode = 1'b0; req_kind = K_WRITE; req_addr = 16'h2468; wr_byte = 8'h5D;
    do @(negedge clk); while (!cycle_start);
    req_kind = K_IDLE;
    repeat (4) @(negedge clk);
    chk("R7", "wr low mid window", wr_n, 0);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "reset mid cycle", {ale, psen_n, rd_n, wr_n, p0_oe}, 5'b01110);
    rst = 1'b0;

    // R2: mode change takes effect only at the next boundary
    x2_mode = 1'b1; req_kind = K_FETCH; ext_code_en = 1'b0; req_addr = 16'h0200;
    do @(negedge clk); while (!cycle_start);
    begin
      int n = 1;
      @(negedge clk);
      while (!cycle_start) begin n++; @(negedge clk); end
      chk("R2", "x2 cycle clocks", n, 6);
      x2_mode = 1'b0;
      n = 1;
      @(negedge clk);
      while (!cycle_start) begin n++; @(negedge clk); end
      chk("R2", "cycle clocks after switch back", n, 6);
      n = 1;
      @(negedge clk);
      while (!cycle_start) begin n++; @(negedge clk); end
      chk("R2", "normal cycle clocks", n, 12);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule